// File: doc/BRIEF.md
# Dual-Polarity Gated Decade Counter

This block is a single-digit BCD counter clocked by a free-running system clock. Two slow external control levels drive it. The count moves forward on a rising edge of the first control while the second is high. It also moves forward on a falling edge of the second control while the first is low. Either control can therefore act as the count pulse while the other acts as its gate. The two controls are brought into the clock domain before their edges are detected.

An active-high master reset clears the digit at once, whatever the clock and the controls are doing. Its release is aligned to the clock. A terminal flag is high while the digit reads nine. Several digits can then be chained into a synchronous multi-digit counter, with the terminal flag of each digit gating the count input of the next.

The controls carry no data, so they are plain level pins with no valid/ready handshake and no back-pressure. Every level on them is sampled once per clock.

Top module: `bcd_edge_counter`

## Requirements
- R1: While `rst_in` is high, `count_o` is 0 and `term_o` is 0. The clear takes effect as soon as `rst_in` rises, without waiting for a clock edge.
- R2: A low-to-high change of `rise_ctl_in` while `fall_ctl_in` is high advances `count_o` by one.
- R3: A high-to-low change of `fall_ctl_in` while `rise_ctl_in` is low advances `count_o` by one.
- R4: A rising `rise_ctl_in` while `fall_ctl_in` is low leaves `count_o` unchanged. A falling `fall_ctl_in` while `rise_ctl_in` is high also leaves `count_o` unchanged.
- R5: A falling `rise_ctl_in` and a rising `fall_ctl_in` never change `count_o`. `count_o` changes only after a qualifying edge or on reset.
- R6: `count_o` is a BCD digit (4 bits, binary weights 8-4-2-1). It steps 0,1,...,9 and then returns to 0 on the next advance.
- R7: `term_o` is high exactly while `count_o` equals 9.
- R8: The gate level used for an edge is the other control's level after the same clock sample. When `rise_ctl_in` rises while `fall_ctl_in` falls, no advance occurs, because each edge sees the other control already in its blocking level.
- R9: A qualifying edge on a control appears on `count_o` after the third rising clock edge following the input change: two synchroniser stages, then the count register.
- R10: On the first two rising clock edges after `rst_in` falls, `count_o` stays 0. Edges sampled while the reset was in force are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock, rising edge active |
| rst_in | input | 1 | Master reset, active high; asynchronous assert, synchronised release |
| rise_ctl_in | input | 1 | Control that counts on its rising edge and gates the other control's falling edge |
| fall_ctl_in | input | 1 | Control that counts on its falling edge and gates the other control's rising edge |
| count_o | output | 4 | BCD digit, 0 to 9 |
| term_o | output | 1 | High while the digit is 9 |

## Verification
The bound checker watches every cycle for these rules:
- reset holds the digit at zero;
- the terminal flag matches the digit;
- the digit only ever steps by one or wraps from nine to zero;
- a step only follows a qualified edge from the edge stage;
- the digit stays at zero through the first two clocks after reset is released.

Some behaviours need directed stimulus, and only the bench's scenarios show them against its cycle model:
- which edge and gate combinations count and which are ignored;
- the blocking of simultaneous opposite moves;
- the exact three-edge latency;
- an edge staged just before reset release being dropped;
- a reset raised in the middle of a clock period clearing the digit before the next edge.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned DIGIT_MAX = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef struct packed {
    logic up_hit;
    logic dn_hit;
  } edge_ev_t;

  // Next BCD value; any out-of-range code also falls back to zero.
  function automatic digit_t digit_next(input digit_t cur);
    if (cur >= digit_t'(DIGIT_MAX)) return '0;
    return cur + digit_t'(1);
  endfunction
endpackage

// File: rtl/bcd_sync.sv
module bcd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  localparam int unsigned TOP = STAGES - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      chain <= {chain[TOP-1:0], d_in[i]};
    end
    assign q_out[i] = chain[TOP];
  end
endmodule

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_in,
  output logic hold_o
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or posedge arst_in) begin
    if (arst_in) pipe <= '1;
    else         pipe <= {pipe[TOP-1:0], 1'b0};
  end

  assign hold_o = pipe[TOP];
endmodule

// File: rtl/bcd_edge_qual.sv
module bcd_edge_qual
  import bcd_cnt_pkg::*;
(
  input  logic     clk,
  input  logic     up_s,
  input  logic     dn_s,
  output edge_ev_t ev_o,
  output logic     adv_o
);
  logic up_prev;
  logic dn_prev;
  logic up_rise;
  logic dn_fall;

  always_ff @(posedge clk) begin
    up_prev <= up_s;
    dn_prev <= dn_s;
  end

  assign up_rise = up_s & ~up_prev;
  assign dn_fall = dn_prev & ~dn_s;

  always_comb begin
    ev_o.up_hit = up_rise & dn_s;
    ev_o.dn_hit = dn_fall & ~up_s;
    adv_o       = ev_o.up_hit | ev_o.dn_hit;
  end
endmodule

// File: rtl/bcd_count_core.sv
module bcd_count_core
  import bcd_cnt_pkg::*;
(
  input  logic   clk,
  input  logic   arst_in,
  input  logic   hold_in,
  input  logic   adv_in,
  output digit_t count_o,
  output logic   term_o
);
  digit_t cnt_q;

  always_ff @(posedge clk or posedge arst_in) begin
    if (arst_in)      cnt_q <= '0;
    else if (hold_in) cnt_q <= '0;
    else if (adv_in)  cnt_q <= digit_next(cnt_q);
  end

  assign count_o = cnt_q;
  assign term_o  = (cnt_q == digit_t'(DIGIT_MAX));
endmodule

// File: rtl/bcd_edge_counter.sv
module bcd_edge_counter
  import bcd_cnt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_in,
  input  logic               rise_ctl_in,
  input  logic               fall_ctl_in,
  output logic [DIGIT_W-1:0] count_o,
  output logic               term_o
);
  localparam int unsigned N_CTL = 2;

  logic [N_CTL-1:0] ctl_raw;
  logic [N_CTL-1:0] ctl_s;
  logic             hold;
  edge_ev_t         ev;
  logic             adv;
  digit_t           digit;

  assign ctl_raw = {fall_ctl_in, rise_ctl_in};

  bcd_sync #(.WIDTH(N_CTL), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .d_in (ctl_raw),
    .q_out(ctl_s)
  );

  bcd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_in(rst_in),
    .hold_o (hold)
  );

  bcd_edge_qual u_edge (
    .clk  (clk),
    .up_s (ctl_s[0]),
    .dn_s (ctl_s[1]),
    .ev_o (ev),
    .adv_o(adv)
  );

  bcd_count_core u_core (
    .clk    (clk),
    .arst_in(rst_in),
    .hold_in(hold),
    .adv_in (adv),
    .count_o(digit),
    .term_o (term_o)
  );

  assign count_o = digit;
endmodule

// File: rtl/bcd_edge_counter_chk.sv
module bcd_edge_counter_chk (
  input logic       clk,
  input logic       rst_in,
  input logic [3:0] count,
  input logic       term,
  input logic       adv
);
  // R1: digit is zero whenever reset is sampled high
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst_in |-> (count == 4'd0 && !term));

  // R7: flag matches a digit of nine
  assert_term_flag_R7: assert property (@(posedge clk) disable iff (rst_in)
    (term == (count == 4'd9)));

  // R6: digit moves only by one step or wraps nine to zero
  assert_bcd_step_R6: assert property (@(posedge clk) disable iff (rst_in)
    (count != $past(count)) |->
      (($past(count) == 4'd9) ? (count == 4'd0) : (count == $past(count) + 4'd1)));

  // R5: a change needs a qualified edge on the previous cycle
  assert_no_stray_step_R5: assert property (@(posedge clk) disable iff (rst_in)
    (count != $past(count)) |-> $past(adv));

  // R10: digit held at zero across the two clocks after release
  assert_release_hold_R10: assert property (@(posedge clk) disable iff (rst_in)
    ($past(rst_in, 2) || $past(rst_in, 3)) |-> (count == 4'd0));
endmodule

bind bcd_edge_counter bcd_edge_counter_chk u_chk (
  .clk   (clk),
  .rst_in(rst_in),
  .count (count_o),
  .term  (term_o),
  .adv   (adv)
);

// File: tb/bcd_edge_counter_tb_top.sv
module bcd_edge_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ra  = 1'b0;
  logic       fb  = 1'b1;
  logic [3:0] cnt;
  logic       tc;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  string cur_req = "R1";

  // behavioural reference
  int  m_cnt = 0;
  int  low_edges = 0;
  bit  ah [$] = '{0, 0, 0};
  bit  bh [$] = '{0, 0, 0};

  always #4 clk = ~clk;

  bcd_edge_counter dut_i (
    .clk        (clk),
    .rst_in     (rst),
    .rise_ctl_in(ra),
    .fall_ctl_in(fb),
    .count_o    (cnt),
    .term_o     (tc)
  );

  always @(posedge rst) m_cnt = 0;

  always @(posedge clk) begin
    bit qual_up, qual_dn;
    // ah[0] = sample one edge back, ah[1] two back, ah[2] three back
    qual_up = ah[1] && !ah[2] && bh[1];
    qual_dn = !bh[1] && bh[2] && !ah[1];
    if (rst) begin
      m_cnt = 0;
      low_edges = 0;
    end else begin
      if (low_edges >= 2 && (qual_up || qual_dn))
        m_cnt = (m_cnt >= 9) ? 0 : m_cnt + 1;
      if (low_edges < 10) low_edges++;
    end
    ah.push_front(ra); void'(ah.pop_back());
    bh.push_front(fb); void'(bh.pop_back());
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model every cycle
  always @(negedge clk) begin
    if (!done) begin
      check(int'(cnt) == m_cnt, cur_req, int'(cnt), m_cnt);
      check(tc == (m_cnt == 9), "R7", int'(tc), int'(m_cnt == 9));
    end
  end

  task automatic drv(input bit a, input bit b, input int waitn);
    @(negedge clk);
    ra = a;
    fb = b;
    repeat (waitn) @(negedge clk);
  endtask

  task automatic expect_cnt(input string req, input int exp);
    check(int'(cnt) == exp, req, int'(cnt), exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    expect_cnt("R1", 0);
    check(tc == 1'b0, "R1", int'(tc), 0);

    // R10: rising edge staged while reset still high is discarded
    cur_req = "R10";
    @(negedge clk); ra = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (5) @(negedge clk);
    expect_cnt("R10", 0);

    // R5: falling rise-control while gate high
    cur_req = "R5";
    drv(0, 1, 4);
    expect_cnt("R5", 0);

    // R9: latency of three clock edges
    cur_req = "R9";
    @(negedge clk); ra = 1'b1;
    @(negedge clk); expect_cnt("R9", 0);
    @(negedge clk); expect_cnt("R9", 0);
    @(negedge clk); expect_cnt("R9", 1);
    repeat (2) @(negedge clk);

    // R2 / R6: count on rising control up through wrap
    cur_req = "R2";
    for (int i = 2; i <= 10; i++) begin
      drv(0, 1, 2);
      drv(1, 1, 4);
      expect_cnt((i < 10) ? "R2" : "R6", i % 10);
      if (i == 9)  check(tc == 1'b1, "R7", int'(tc), 1);
      if (i == 10) check(tc == 1'b0, "R7", int'(tc), 0);
    end

    // R3: count on falling control with gate low; R5 rising is ignored
    cur_req = "R3";
    drv(0, 1, 4);
    expect_cnt("R5", 0);
    for (int j = 1; j <= 3; j++) begin
      drv(0, 0, 4);
      expect_cnt("R3", j);
      drv(0, 1, 4);
      expect_cnt("R5", j);
    end

    // R4: edges against a blocking gate
    cur_req = "R4";
    drv(0, 0, 4);
    expect_cnt("R3", 4);
    drv(1, 0, 4);
    expect_cnt("R4", 4);
    drv(0, 0, 4);
    expect_cnt("R5", 4);
    drv(0, 1, 4);
    expect_cnt("R5", 4);
    drv(1, 1, 4);
    expect_cnt("R2", 5);
    drv(1, 0, 4);
    expect_cnt("R4", 5);

    // R8: opposite moves in the same sample
    cur_req = "R8";
    drv(0, 1, 4);
    expect_cnt("R8", 5);
    drv(1, 0, 4);
    expect_cnt("R8", 5);

    // R1: asynchronous clear mid-period
    cur_req = "R1";
    drv(0, 1, 4);
    @(negedge clk);
    #1 rst = 1'b1;
    #1 expect_cnt("R1", 0);
    @(negedge clk); rst = 1'b0;
    repeat (4) @(negedge clk);
    cur_req = "R2";
    drv(1, 1, 4);
    expect_cnt("R2", 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule